// File: doc/BRIEF.md
# SPI Interrupt Flag and Clear Unit

This unit keeps the four interrupt flags of an SPI controller and turns them into one interrupt request. The data path raises a one-cycle event pulse when a frame has been sent, when a frame has arrived, when the receive side overflows, or when the transmit side underruns. Each pulse sets a sticky flag. Each flag stays set until software clears it.

Software sees two read-only views of the flags. The raw view shows every flag. The masked view shows only the flags whose enable bit is set in the controller's control word. Software clears flags by writing ones to a separate clear register. The interrupt output goes high only while at least one enabled flag is set. This keeps a shared interrupt line quiet when the controller has nothing to report.

The control word is held outside this unit. Only its four enable bits (control bits 4 to 7) are brought in.

Top module: `spi_irq_unit`

## Requirements
- R1: After reset all four flags are clear, both status views read zero and `irq` is low.
- R2: A one-cycle pulse on `evt[i]` sets flag i on the next clock edge. The flag then holds until it is cleared. Bit order: 0 transmit done, 1 receive ready, 2 receive overflow, 3 transmit underrun.
- R3: A read at offset 0x24 returns the raw flags in bits 3:0, and bits above 3 read as zero.
- R4: A read at offset 0x20 returns each raw flag ANDed with its enable, with bits above 3 reading as zero. The enables map as follows:
  - `ien[1]` (control bit 5) gates transmit done.
  - `ien[0]` (control bit 4) gates receive ready.
  - `ien[2]` (control bit 6) gates overflow.
  - `ien[3]` (control bit 7) gates underrun.
- R5: A write to offset 0x0c clears every flag whose `wdata` bit (3:0) is 1 and leaves every flag whose bit is 0 unchanged.
- R6: When an event pulse and a clear for the same flag occur in the same cycle, the flag ends up set.
- R7: `irq` is the OR of the four masked bits. It stays low whenever no enabled flag is set, even if disabled flags are set.
- R8: Reads at any other offset return zero, and writes to any other offset leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt | input | 4 | One-cycle event pulses, in flag bit order |
| ien | input | 4 | Control word bits 7:4 (interrupt enables) |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (6) | Register byte offset |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume the following about the inputs:
- `evt` is a set of independent pulses that may arrive in any cycle, including the cycle of a clear.
- `addr` and `wr_en` are stable across each clock edge.
- `ien` may change at any time, because `irq` and the masked view follow it without a register.

The directed stimulus drives every input on the falling clock edge. It holds each bus access for exactly one cycle. It deliberately lines an event up with a clear of the same bit, so the race in R6 is exercised within those assumptions.

// File: rtl/spi_irq_unit.sv
`timescale 1ns/1ps
module spi_irq_unit #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 6,
  parameter logic [ADDR_W-1:0] OFS_CLR = 6'h0c,
  parameter logic [ADDR_W-1:0] OFS_MSK = 6'h20,
  parameter logic [ADDR_W-1:0] OFS_RAW = 6'h24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        evt,
  input  logic [3:0]        ien,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int NSRC = 4;
  localparam int PAD  = DATA_W - NSRC;

  logic [NSRC-1:0] raw_q;
  logic [NSRC-1:0] en_vec;
  logic [NSRC-1:0] masked;
  logic [NSRC-1:0] clr_mask;
  logic            unused_wdata;

  assign unused_wdata = ^wdata[DATA_W-1:NSRC];

  // control bit 5 gates flag 0, bit 4 gates flag 1
  assign en_vec   = {ien[3], ien[2], ien[0], ien[1]};
  assign masked   = raw_q & en_vec;
  assign clr_mask = (wr_en && addr == OFS_CLR) ? wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= (raw_q & ~clr_mask) | evt;
  end

  always_comb begin
    rdata = '0;
    if (addr == OFS_MSK)      rdata = {{PAD{1'b0}}, masked};
    else if (addr == OFS_RAW) rdata = {{PAD{1'b0}}, raw_q};
  end

  assign irq = |masked;
endmodule

module spi_irq_unit_chk #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 6,
  parameter logic [ADDR_W-1:0] OFS_CLR = 6'h0c,
  parameter logic [ADDR_W-1:0] OFS_MSK = 6'h20,
  parameter logic [ADDR_W-1:0] OFS_RAW = 6'h24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        evt,
  input logic [3:0]        ien,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic [3:0]        raw_q
);
  logic clr_wr;
  assign clr_wr = wr_en && addr == OFS_CLR;

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt != 4'b0 |=> (raw_q & $past(evt)) == $past(evt));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && evt == 4'b0) |=> $stable(raw_q));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (raw_q & $past(wdata[3:0]) & ~$past(evt)) == 4'b0);

  p_race_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && (wdata[3:0] & evt) != 4'b0) |=> (raw_q & $past(wdata[3:0] & evt)) != 4'b0);

  p_raw_view_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr == OFS_RAW |-> rdata == {{(DATA_W-4){1'b0}}, raw_q});

  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_MSK && rdata == '0) |-> !irq);

  p_other_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != OFS_MSK && addr != OFS_RAW) |-> rdata == '0);
endmodule

bind spi_irq_unit spi_irq_unit_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .OFS_CLR(OFS_CLR), .OFS_MSK(OFS_MSK), .OFS_RAW(OFS_RAW)
) u_chk (.*);

// File: tb/spi_irq_unit_bench.sv
`timescale 1ns/1ps
module spi_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  evt = '0;
  logic [3:0]  ien = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  localparam logic [5:0] A_CLR = 6'h0c;
  localparam logic [5:0] A_MSK = 6'h20;
  localparam logic [5:0] A_RAW = 6'h24;

  spi_irq_unit u_spi_irq_unit (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual hung, expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] mask_of(logic [3:0] flags, logic [3:0] e);
    return flags & {e[3], e[2], e[0], e[1]};
  endfunction

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic pulse(logic [3:0] e);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_RAW, d); chk("R1 raw", d, 0);
    rd(A_MSK, d); chk("R1 masked", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_set_each;
    logic [31:0] d;
    logic [3:0] acc = '0;
    for (int i = 0; i < 4; i++) begin
      pulse(4'b1 << i);
      acc[i] = 1'b1;
      rd(A_RAW, d); chk("R2 set", d, {28'b0, acc});
    end
    repeat (3) @(negedge clk);
    rd(A_RAW, d); chk("R2 hold R3 upper zero", d, 32'h0000000f);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    for (int e = 0; e < 16; e++) begin
      ien = e[3:0];
      rd(A_MSK, d); chk("R4 masked", d, {28'b0, mask_of(4'hf, e[3:0])});
      chk("R7 irq", {31'b0, irq}, {31'b0, e != 0});
    end
    ien = 4'b0001;
    wr(A_CLR, 32'h1);
    rd(A_MSK, d); chk("R4 rx ready gated by bit 4", d, 32'h2);
    ien = 4'b0010;
    rd(A_MSK, d); chk("R4 tx done gated by bit 5", d, 32'h0);
    chk("R7 quiet with disabled flags", {31'b0, irq}, 0);
    pulse(4'h1);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr(A_CLR, 32'hffff_fff0);
    rd(A_RAW, d); chk("R5 zeros keep flags", d, 32'hf);
    wr(A_CLR, 32'ha);
    rd(A_RAW, d); chk("R5 ones clear", d, 32'h5);
    wr(A_CLR, 32'h5);
    rd(A_RAW, d); chk("R5 all clear", d, 32'h0);
    ien = 4'hf;
    chk("R7 irq low after clear", {31'b0, irq}, 0);
  endtask

  task automatic t_race;
    logic [31:0] d;
    pulse(4'hf);
    evt = 4'b0100;
    wr(A_CLR, 32'hf);
    evt = '0;
    rd(A_RAW, d); chk("R6 event wins", d, 32'h4);
    rd(A_MSK, d); chk("R6 masked", d, 32'h4);
    chk("R7 irq from overflow", {31'b0, irq}, 1);
  endtask

  task automatic t_other;
    logic [31:0] d;
    rd(6'h08, d); chk("R8 read other", d, 0);
    rd(6'h28, d); chk("R8 read other 2", d, 0);
    wr(6'h10, 32'hf);
    wr(6'h20, 32'hf);
    rd(A_RAW, d); chk("R8 write elsewhere", d, 32'h4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_each();
    t_mask();
    t_clear();
    t_race();
    t_other();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule